// File: doc/BRIEF.md
# Digit-Decoded Inner Product Unit

This block forms the filter output of a delayed least-mean-square adaptive filter. It takes a vector of signed input samples and a vector of signed tap weights, and computes their inner product without general multipliers. Every sample is cut into 2-bit digits. Each digit is decoded into three one-hot select lines. These lines choose a precomputed single, double or triple copy of the tap weight as a partial product.

The partial products that share a digit position are first summed across all taps, with one adder tree per position. The position sums then enter a single shift-add stage that weights each one by its power of four. The same stage subtracts a sign-correction term for samples whose top bit is set. The result is subtracted from a desired sample to form the error that drives weight adaptation elsewhere.

The unit is fully pipelined. A new vector may be presented on every clock. Results leave in order, after a fixed delay, with a valid flag.

Top module: `dd_inner_product`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `y_out` and `err_out` are all zero until the first result emerges.
- R2: `y_out` equals the exact signed sum over all taps of sample times weight. Sample t occupies bits [t*XW +: XW] of `samples` and weight t occupies bits [t*WW +: WW] of `weights`, both in two's complement.
- R3: `err_out` equals the signed value of `desired` minus `y_out`, exactly, in OW+1 bits, with both values taken from the same input vector.
- R4: `out_valid` is high exactly 3 clock cycles after `in_valid` was sampled high. Back-to-back inputs give back-to-back results in order.
- R5: A sample whose digits are all 00 contributes nothing. An all-zero sample vector yields `y_out` of zero.
- R6: The most negative sample and weight codes (only the top bit set) yield exact products, including when all taps hold them at once.
- R7: While `out_valid` is low, `y_out` and `err_out` keep their last values.
- R8: An all-zero weight vector yields `y_out` of zero whatever the samples are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input vector is valid this cycle |
| samples | input | TAPS*XW | Packed signed input samples |
| weights | input | TAPS*WW | Packed signed tap weights |
| desired | input | OW | Signed desired sample |
| out_valid | output | 1 | Result valid |
| y_out | output | OW | Signed filter output |
| err_out | output | OW+1 | Signed error, desired minus output |

## Verification
The case that is hardest to reach from the ports is a negative top digit on every tap at once, combined with extreme weights. In that case the sign-correction term and the position sums all push the result to the edge of the output width. Random vectors rarely land there. The bench therefore sweeps every sample and weight pair exhaustively on rotating taps, and then drives vectors with all taps at the most negative code and mixed extremes. Idle gaps between bursts show that the outputs hold.

// File: rtl/dd_ip_pkg.sv
package dd_ip_pkg;
    typedef struct packed {
        logic pick1;
        logic pick2;
        logic pick3;
    } dsel_t;

    function automatic dsel_t decode_digit(input logic [1:0] dg);
        dsel_t s;
        s.pick1 = dg[0] & ~dg[1];
        s.pick2 = dg[1] & ~dg[0];
        s.pick3 = dg[1] & dg[0];
        return s;
    endfunction
endpackage

// File: rtl/dd_digit_select.sv
module dd_digit_select
    import dd_ip_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic [1:0]    digit,
    input  logic [PW-1:0] mult1,
    input  logic [PW-1:0] mult2,
    input  logic [PW-1:0] mult3,
    output logic [PW-1:0] pp
);
    dsel_t sel;

    always_comb begin
        sel = decode_digit(digit);
        pp  = ({PW{sel.pick1}} & mult1)
            | ({PW{sel.pick2}} & mult2)
            | ({PW{sel.pick3}} & mult3);
    end
endmodule

// File: rtl/dd_column_sum.sv
module dd_column_sum #(
    parameter int N  = 4,
    parameter int IW = 8,
    parameter int SW = 10
) (
    input  logic [N*IW-1:0] terms,
    output logic [SW-1:0]   total
);
    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++) begin
            total = total + {{(SW-IW){terms[i*IW+IW-1]}}, terms[i*IW +: IW]};
        end
    end
endmodule

// File: rtl/dd_inner_product.sv
module dd_inner_product #(
    parameter int TAPS = 4,
    parameter int XW   = 6,
    parameter int WW   = 6,
    parameter int OW   = XW + WW + $clog2(TAPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [TAPS*XW-1:0]   samples,
    input  logic [TAPS*WW-1:0]   weights,
    input  logic [OW-1:0]        desired,
    output logic                 out_valid,
    output logic [OW-1:0]        y_out,
    output logic [OW:0]          err_out
);
    localparam int ND = XW / 2;
    localparam int PW = WW + 2;
    localparam int CW = PW + $clog2(TAPS);

    logic [TAPS*PW-1:0] col_in [ND];
    logic [TAPS*PW-1:0] neg_in;
    logic [CW-1:0]      col_sum [ND];
    logic [CW-1:0]      corr_sum;

    // partial products per tap and digit
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        logic [PW-1:0] m1, m2, m3;
        logic          xneg;
        assign m1   = {{2{weights[t*WW+WW-1]}}, weights[t*WW +: WW]};
        assign m2   = {m1[PW-2:0], 1'b0};
        assign m3   = m1 + m2;
        assign xneg = samples[t*XW+XW-1];
        assign neg_in[t*PW +: PW] = xneg ? m1 : '0;
        for (genvar d = 0; d < ND; d++) begin : g_dig
            dd_digit_select #(.PW(PW)) u_sel (
                .digit (samples[t*XW+2*d +: 2]),
                .mult1 (m1),
                .mult2 (m2),
                .mult3 (m3),
                .pp    (col_in[d][t*PW +: PW])
            );
        end
    end

    // one adder tree per digit position
    for (genvar d = 0; d < ND; d++) begin : g_col
        dd_column_sum #(.N(TAPS), .IW(PW), .SW(CW)) u_col (
            .terms (col_in[d]),
            .total (col_sum[d])
        );
    end

    dd_column_sum #(.N(TAPS), .IW(PW), .SW(CW)) u_corr (
        .terms (neg_in),
        .total (corr_sum)
    );

    // stage 1: position sums
    logic [CW-1:0] s1_col [ND];
    logic [CW-1:0] s1_corr;
    logic [OW-1:0] s1_des;
    logic          s1_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int d = 0; d < ND; d++) s1_col[d] <= '0;
            s1_corr <= '0;
            s1_des  <= '0;
            s1_v    <= 1'b0;
        end else begin
            s1_v <= in_valid;
            if (in_valid) begin
                for (int d = 0; d < ND; d++) s1_col[d] <= col_sum[d];
                s1_corr <= corr_sum;
                s1_des  <= desired;
            end
        end
    end

    // shift-add tree
    logic [OW-1:0] y_comb;
    always_comb begin
        y_comb = '0;
        for (int d = 0; d < ND; d++) begin
            y_comb = y_comb + ({{(OW-CW){s1_col[d][CW-1]}}, s1_col[d]} << (2*d));
        end
        y_comb = y_comb - ({{(OW-CW){s1_corr[CW-1]}}, s1_corr} << XW);
    end

    // stage 2: filter output
    logic [OW-1:0] s2_y;
    logic [OW-1:0] s2_des;
    logic          s2_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_y   <= '0;
            s2_des <= '0;
            s2_v   <= 1'b0;
        end else begin
            s2_v <= s1_v;
            if (s1_v) begin
                s2_y   <= y_comb;
                s2_des <= s1_des;
            end
        end
    end

    // stage 3: error
    logic [OW:0] err_comb;
    assign err_comb = {s2_des[OW-1], s2_des} - {s2_y[OW-1], s2_y};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_out     <= '0;
            err_out   <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= s2_v;
            if (s2_v) begin
                y_out   <= s2_y;
                err_out <= err_comb;
            end
        end
    end
endmodule

// File: rtl/dd_ip_checker.sv
module dd_ip_checker #(
    parameter int TAPS = 4,
    parameter int XW   = 6,
    parameter int WW   = 6,
    parameter int OW   = XW + WW + $clog2(TAPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [TAPS*XW-1:0] samples,
    input  logic [TAPS*WW-1:0] weights,
    input  logic [OW-1:0]      desired,
    input  logic               out_valid,
    input  logic [OW-1:0]      y_out,
    input  logic [OW:0]        err_out
);
    logic [1:0] since;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) since <= '0;
        else if (since != 2'd3) since <= since + 2'd1;
    end

    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    a_r3_error: assert property (@(posedge clk) disable iff (!rst_n)
        (since == 2'd3 && out_valid) |->
        ($signed(err_out) == $signed({$past(desired[OW-1], 3), $past(desired, 3)}) - $signed({y_out[OW-1], y_out})));

    a_r5_zero_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (since == 2'd3 && $past(in_valid, 3) && $past(samples, 3) == '0) |-> (y_out == '0));

    a_r8_zero_weight: assert property (@(posedge clk) disable iff (!rst_n)
        (since == 2'd3 && $past(in_valid, 3) && $past(weights, 3) == '0) |-> (y_out == '0));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (since != 2'd0 && !out_valid) |-> ($stable(y_out) && $stable(err_out)));

    a_r1_idle_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (since != 2'd3) |-> (!out_valid && y_out == '0 && err_out == '0));
endmodule

bind dd_inner_product dd_ip_checker #(.TAPS(TAPS), .XW(XW), .WW(WW), .OW(OW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .samples(samples),
    .weights(weights), .desired(desired), .out_valid(out_valid),
    .y_out(y_out), .err_out(err_out)
);

// File: tb/test_dd_inner_product.sv
module test_dd_inner_product;
    localparam int TAPS = 4;
    localparam int XW   = 6;
    localparam int WW   = 6;
    localparam int OW   = XW + WW + $clog2(TAPS);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [TAPS*XW-1:0] samples = '0;
    logic [TAPS*WW-1:0] weights = '0;
    logic [OW-1:0]      desired = '0;
    logic               out_valid;
    logic [OW-1:0]      y_out;
    logic [OW:0]        err_out;

    always #4 clk = ~clk;

    dd_inner_product #(.TAPS(TAPS), .XW(XW), .WW(WW)) i_dd_inner_product (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .samples(samples),
        .weights(weights), .desired(desired), .out_valid(out_valid),
        .y_out(y_out), .err_out(err_out)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;
    int    q_y[$];
    int    q_e[$];
    string q_tag[$];
    bit    vhist[3] = '{0, 0, 0};
    int    last_y = 0;
    int    last_e = 0;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle: observe outputs at the falling edge, then drive next inputs
    task automatic cyc(input bit v, input int x[TAPS], input int w[TAPS], input int d,
                       input string tag);
        int ya, ea, ey;
        @(negedge clk);
        ya = int'($signed(y_out));
        ea = int'($signed(err_out));
        check("R4 valid timing", int'(out_valid), int'(vhist[2]));
        if (out_valid && q_y.size() > 0) begin
            string t;
            t = q_tag.pop_front();
            check({t, " R2 output"}, ya, q_y.pop_front());
            check({t, " R3 error"}, ea, q_e.pop_front());
            last_y = ya;
            last_e = ea;
        end else if (!out_valid) begin
            check("R7 hold output", ya, last_y);
            check("R7 hold error", ea, last_e);
        end
        vhist[2] = vhist[1];
        vhist[1] = vhist[0];
        vhist[0] = v;
        in_valid = v;
        if (v) begin
            ey = 0;
            for (int t = 0; t < TAPS; t++) begin
                samples[t*XW +: XW] = x[t][XW-1:0];
                weights[t*WW +: WW] = w[t][WW-1:0];
                ey += x[t] * w[t];
            end
            desired = d[OW-1:0];
            q_y.push_back(ey);
            q_e.push_back(d - ey);
            q_tag.push_back(tag);
        end
    endtask

    function automatic int rnd_s(input int bits);
        int r;
        r = $urandom_range((1 << bits) - 1, 0);
        return r - (1 << (bits - 1));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int x[TAPS];
        int w[TAPS];
        int z[TAPS];
        int xn = -(1 << (XW - 1));
        int wn = -(1 << (WW - 1));
        foreach (z[i]) z[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset y", int'(y_out), 0);
        check("R1 reset err", int'(err_out), 0);
        rst_n = 1'b1;
        repeat (2) cyc(0, z, z, 0, "R1");
        check("R1 after reset valid", int'(out_valid), 0);

        // R2/R6: exhaustive single-tap products on rotating taps
        for (int xv = xn; xv < -xn; xv++) begin
            for (int wv = wn; wv < -wn; wv++) begin
                foreach (x[i]) begin x[i] = 0; w[i] = 0; end
                x[(xv + wv) & (TAPS - 1)] = xv;
                w[(xv + wv) & (TAPS - 1)] = wv;
                cyc(1, x, w, rnd_s(OW), "R6 sweep");
            end
        end
        repeat (5) cyc(0, z, z, 0, "R7");

        // R6: all taps at the most negative code
        foreach (x[i]) begin x[i] = xn; w[i] = wn; end
        cyc(1, x, w, -(1 << (OW - 1)), "R6 all min");
        foreach (x[i]) begin x[i] = xn; w[i] = -wn - 1; end
        cyc(1, x, w, (1 << (OW - 1)) - 1, "R6 min x max w");
        foreach (x[i]) begin x[i] = -xn - 1; w[i] = wn; end
        cyc(1, x, w, 0, "R6 max x min w");
        repeat (4) cyc(0, z, z, 0, "R7");

        // R5: zero samples, R8: zero weights
        for (int k = 0; k < 20; k++) begin
            foreach (w[i]) w[i] = rnd_s(WW);
            cyc(1, z, w, rnd_s(OW), "R5 zero samples");
            foreach (x[i]) x[i] = rnd_s(XW);
            cyc(1, x, z, rnd_s(OW), "R8 zero weights");
        end
        repeat (4) cyc(0, z, z, 0, "R7");

        // R2/R3/R4: random vectors with random gaps
        for (int k = 0; k < 2000; k++) begin
            bit v;
            v = ($urandom_range(3, 0) != 0);
            foreach (x[i]) begin x[i] = rnd_s(XW); w[i] = rnd_s(WW); end
            cyc(v, x, w, rnd_s(OW), "R2 random");
        end
        repeat (6) cyc(0, z, z, 0, "R7");
        check("R4 all results seen", q_y.size(), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule